// File: doc/BRIEF.md
# Dual-Compare 8-bit Timer Channel

This block is one 8-bit up-counting timer channel. Its count advances on ticks taken either from an internal prescaler, selectable in seven ratios from divide-by-1 to divide-by-8192, or from an event input that adds one count for each cycle it is held high. Two compare registers, A and B, are checked against the count on every tick. Either match can raise a one-cycle interrupt pulse. Either match can also be chosen to return the counter to zero, which makes the channel a periodic timer with a period set by software.

Software reaches the channel through a plain, always-accepted write port. One address each selects the control register, the clock control register, compare A, compare B and the counter itself. Writes need no handshake and cannot be held off. A write to the counter overrides counting in that cycle and restarts the prescaler phase, so the next internal tick comes one full divider period later. The current count and the three interrupt pulses are the block's outputs.

Top module: `tmr8_channel`

## Requirements
- R1: After reset the count is 0x00, the control and clock control registers are 0x00 so nothing counts, and compare A and compare B both hold 0xFF.
- R2: With clock control bits 4:3 equal to 1 and bits 2:0 equal to a value from 0 to 6, the counter advances by one every 1, 2, 8, 32, 64, 1024 or 8192 system clock cycles respectively.
- R3: The counter holds its value when clock control bits 2:0 equal 7 with the internal source selected, or when clock control bits 4:3 equal 0 or 2.
- R4: With clock control bits 4:3 equal to 3, the counter advances by one for each system clock cycle in which `evt_i` is high, and the divider bits have no effect.
- R5: On a tick where the count equals compare A (or B), output `irq_cmpa_o` (or `irq_cmpb_o`) is high for the cycle after that clock edge, but only if control bit 6 (compare A) or bit 7 (compare B) is set.
- R6: Control bits 4:3 select the clear source. With value 1, a tick that matches compare A loads 0 instead of incrementing. With value 2, compare B does the same. Values 0 and 3 never clear.
- R7: A tick at count 0xFF that is not a clearing match wraps the count to 0x00, and `irq_ovf_o` goes high for one cycle only if control bit 5 is set. A clearing match at 0xFF raises no overflow pulse.
- R8: A write to the counter loads the written value and suppresses any tick in that cycle. It also restarts the prescaler, so the next internal tick comes a full divider period after the write.
- R9: Each interrupt output is high for exactly one cycle per qualifying tick, and it is low in every cycle that follows a cycle without one.
- R10: Write addresses are 0 for control, 1 for clock control, 2 for compare A, 3 for compare B and 4 for the counter. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| evt_i | input | 1 | Event count input, one count per high cycle when selected |
| count_o | output | 8 | Current counter value |
| irq_cmpa_o | output | 1 | Compare A match pulse |
| irq_cmpb_o | output | 1 | Compare B match pulse |
| irq_ovf_o | output | 1 | Overflow pulse |

## Verification
A write takes effect at the clock edge where it is sampled. A tick, or a counter write, changes `count_o` at that same edge. The interrupt pulses are registered at the edge of the tick that caused them, so they are seen in the cycle just after that edge, together with the new count. The bench drives and samples on the falling edge. Its reference model steps once per cycle on the inputs it has just applied, so each comparison at the next falling edge matches the result of exactly one rising edge. Long divider ratios run for several whole periods, so every tick position is compared.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int PHASE_W = 13;
  localparam int NUM_CMP = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL   = 3'd0,
    ADR_CLKCTL = 3'd1,
    ADR_CMPA   = 3'd2,
    ADR_CMPB   = 3'd3,
    ADR_COUNT  = 3'd4
  } reg_addr_e;

  // control register bits 7:3
  typedef struct packed {
    logic       cmpb_ie;
    logic       cmpa_ie;
    logic       ovf_ie;
    logic [1:0] clr_sel;
  } ctrl_t;

  // clock control register bits 4:0
  typedef struct packed {
    logic [1:0] src;
    logic [2:0] div_sel;
  } clkctl_t;

  localparam logic [1:0] SRC_INTERNAL = 2'd1;
  localparam logic [1:0] SRC_EVENT    = 2'd3;
  localparam logic [2:0] DIV_STOP     = 3'd7;

  // last phase value of a divider period
  function automatic logic [PHASE_W-1:0] phase_last(input logic [2:0] sel);
    case (sel)
      3'd0:    phase_last = PHASE_W'(0);
      3'd1:    phase_last = PHASE_W'(1);
      3'd2:    phase_last = PHASE_W'(7);
      3'd3:    phase_last = PHASE_W'(31);
      3'd4:    phase_last = PHASE_W'(63);
      3'd5:    phase_last = PHASE_W'(1023);
      3'd6:    phase_last = PHASE_W'(8191);
      default: phase_last = PHASE_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output clkctl_t           clkctl,
  output logic [DATA_W-1:0] cmp [NUM_CMP],
  output logic              cnt_wr,
  output logic [DATA_W-1:0] cnt_wdata
);

  ctrl_t   ctrl_q;
  clkctl_t clkctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      clkctl_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADR_CTRL)   ctrl_q   <= ctrl_t'(wr_data[7:3]);
      if (wr_addr == ADR_CLKCTL) clkctl_q <= clkctl_t'(wr_data[4:0]);
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(ADR_CMPA) + ADDR_W'(g);
    logic [DATA_W-1:0] cmp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cmp_q <= '1;
      else if (wr_en && wr_addr == MY_ADR) cmp_q <= wr_data;
    end
    assign cmp[g] = cmp_q;
  end

  assign ctrl      = ctrl_q;
  assign clkctl    = clkctl_q;
  assign cnt_wr    = wr_en && (wr_addr == ADR_COUNT);
  assign cnt_wdata = wr_data;

endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  clkctl_t clkctl,
  input  logic    restart,
  input  logic    evt_i,
  output logic    tick
);

  logic [PHASE_W-1:0] phase_q;
  logic               internal_run;
  logic               tap_tick;

  assign internal_run = (clkctl.src == SRC_INTERNAL) && (clkctl.div_sel != DIV_STOP);
  assign tap_tick     = internal_run && (phase_q == phase_last(clkctl.div_sel));

  always_comb begin
    if (restart)                       tick = 1'b0;
    else if (clkctl.src == SRC_EVENT)  tick = evt_i;
    else                               tick = tap_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 phase_q <= '0;
    else if (restart || !internal_run || tap_tick) phase_q <= '0;
    else                                        phase_q <= phase_q + 1'b1;
  end

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] cmp [NUM_CMP],
  input  logic              cnt_wr,
  input  logic [DATA_W-1:0] cnt_wdata,
  output logic [DATA_W-1:0] count,
  output logic [NUM_CMP-1:0] irq_cmp,
  output logic              irq_ovf
);

  logic [DATA_W-1:0]  cnt_q;
  logic [NUM_CMP-1:0] hit;
  logic [NUM_CMP-1:0] clr_hit;
  logic [NUM_CMP-1:0] ie;
  logic [NUM_CMP-1:0] irq_q;
  logic               do_clear;
  logic               wrap;
  logic               ovf_q;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_match
    assign hit[g]     = (cnt_q == cmp[g]);
    assign clr_hit[g] = hit[g] && (ctrl.clr_sel == 2'(g + 1));
    if (g == 0) begin : g_ie_a
      assign ie[g] = ctrl.cmpa_ie;
    end else begin : g_ie_b
      assign ie[g] = ctrl.cmpb_ie;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[g] <= 1'b0;
      else        irq_q[g] <= tick && hit[g] && ie[g];
    end
  end

  assign do_clear = tick && (|clr_hit);
  assign wrap     = tick && !(|clr_hit) && (cnt_q == {DATA_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_wr)   cnt_q <= cnt_wdata;
    else if (do_clear) cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= wrap && ctrl.ovf_ie;
  end

  assign count   = cnt_q;
  assign irq_cmp = irq_q;
  assign irq_ovf = ovf_q;

endmodule

// File: rtl/tmr8_channel.sv
module tmr8_channel
  import tmr8_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        evt_i,
  output logic [7:0]  count_o,
  output logic        irq_cmpa_o,
  output logic        irq_cmpb_o,
  output logic        irq_ovf_o
);

  ctrl_t              ctrl;
  clkctl_t            clkctl;
  logic [DATA_W-1:0]  cmp [NUM_CMP];
  logic               cnt_wr;
  logic [DATA_W-1:0]  cnt_wdata;
  logic               cnt_tick;
  logic [NUM_CMP-1:0] irq_cmp;

  tmr8_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctrl      (ctrl),
    .clkctl    (clkctl),
    .cmp       (cmp),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata)
  );

  tmr8_prescaler u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clkctl  (clkctl),
    .restart (cnt_wr),
    .evt_i   (evt_i),
    .tick    (cnt_tick)
  );

  tmr8_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (cnt_tick),
    .ctrl      (ctrl),
    .cmp       (cmp),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .count     (count_o),
    .irq_cmp   (irq_cmp),
    .irq_ovf   (irq_ovf_o)
  );

  assign irq_cmpa_o = irq_cmp[0];
  assign irq_cmpb_o = irq_cmp[1];

endmodule

// File: rtl/tmr8_channel_sva.sv
module tmr8_channel_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cnt_wr,
  input logic [7:0] cnt_wdata,
  input logic [1:0] clr_sel,
  input logic [7:0] cmp_a,
  input logic       ie_a,
  input logic [7:0] count,
  input logic       irq_a,
  input logic       irq_ovf
);

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> count == 8'h00); // R7

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count)); // R3

  AST_CLEAR_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr_sel == 2'd1 && count == cmp_a) |=> count == 8'h00); // R6

  AST_IRQA_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> $past(ie_a)); // R5

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(cnt_wdata)); // R8

endmodule

bind tmr8_channel tmr8_channel_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (cnt_tick),
  .cnt_wr    (cnt_wr),
  .cnt_wdata (cnt_wdata),
  .clr_sel   (ctrl.clr_sel),
  .cmp_a     (cmp[0]),
  .ie_a      (ctrl.cmpa_ie),
  .count     (count_o),
  .irq_a     (irq_cmpa_o),
  .irq_ovf   (irq_ovf_o)
);

// File: tb/tmr8_channel_test.sv
module tmr8_channel_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       evt_i = 1'b0;
  logic [7:0] count_o;
  logic       irq_cmpa_o, irq_cmpb_o, irq_ovf_o;

  int checks = 0;
  int errors = 0;
  string sect = "R1";
  bit evt_rand = 1'b0;
  bit done = 1'b0;

  // reference model state
  logic [7:0]  m_ctrl = 8'h00, m_cc = 8'h00, m_a = 8'hFF, m_b = 8'hFF, m_cnt = 8'h00;
  logic [12:0] m_p = '0;
  logic        m_ia = 1'b0, m_ib = 1'b0, m_io = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr8_channel uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_i(evt_i), .count_o(count_o), .irq_cmpa_o(irq_cmpa_o),
    .irq_cmpb_o(irq_cmpb_o), .irq_ovf_o(irq_ovf_o)
  );

  function automatic int div_of(input logic [2:0] sel);
    case (sel)
      3'd0: return 1;    3'd1: return 2;    3'd2: return 8;
      3'd3: return 32;   3'd4: return 64;   3'd5: return 1024;
      3'd6: return 8192; default: return 0;
    endcase
  endfunction

  task automatic chk8(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", sect, what, act, exp);
    end
  endtask

  task automatic chk1(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/R9 %s actual %b expected %b", sect, what, act, exp);
    end
  endtask

  // one clock: check current outputs, drive inputs, advance the model
  task automatic cyc(input bit we, input logic [2:0] ad, input logic [7:0] d, input bit ev);
    bit internal, tap, tick, cw, ca, cb;
    chk8("count", count_o, m_cnt);
    chk1("irq_cmpa", irq_cmpa_o, m_ia);
    chk1("irq_cmpb", irq_cmpb_o, m_ib);
    chk1("irq_ovf", irq_ovf_o, m_io);
    wr_en = we; wr_addr = ad; wr_data = d; evt_i = ev;
    cw       = we && ad == 3'd4;
    internal = m_cc[4:3] == 2'd1 && m_cc[2:0] != 3'd7;
    tap      = internal && (int'(m_p) == div_of(m_cc[2:0]) - 1);
    tick     = cw ? 1'b0 : (m_cc[4:3] == 2'd3 ? ev : tap);
    ca       = m_ctrl[4:3] == 2'd1 && m_cnt == m_a;
    cb       = m_ctrl[4:3] == 2'd2 && m_cnt == m_b;
    m_ia = tick && m_cnt == m_a && m_ctrl[6];
    m_ib = tick && m_cnt == m_b && m_ctrl[7];
    m_io = tick && !(ca || cb) && m_cnt == 8'hFF && m_ctrl[5];
    m_p  = (cw || !internal || tap) ? 13'd0 : m_p + 13'd1;
    if (cw)                m_cnt = d;
    else if (tick && (ca || cb)) m_cnt = 8'h00;
    else if (tick)         m_cnt = m_cnt + 8'd1;
    if (we) begin
      case (ad)
        3'd0: m_ctrl = {d[7:3], 3'b000};
        3'd1: m_cc   = {3'b000, d[4:0]};
        3'd2: m_a    = d;
        3'd3: m_b    = d;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] ad, input logic [7:0] d);
    cyc(1'b1, ad, d, 1'b0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'h00, evt_rand ? 1'($urandom % 2) : 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then compare A at its reset value 0xFF
    sect = "R1";
    run(3);
    wr(3'd1, 8'h08);
    wr(3'd0, 8'h40);
    run(300);
    // R2: every divider ratio
    sect = "R2";
    wr(3'd0, 8'h00);
    for (int s = 0; s < 7; s++) begin
      wr(3'd4, 8'h00);
      wr(3'd1, 8'(8 + s));
      run(div_of(3'(s)) * 3 + 5);
    end
    // R3: stopped selections
    sect = "R3";
    wr(3'd1, 8'h0F); wr(3'd4, 8'h33); run(40);
    wr(3'd1, 8'h00); run(40);
    wr(3'd1, 8'h10); run(40);
    // R4: event counting
    sect = "R4";
    evt_rand = 1'b1;
    wr(3'd1, 8'h1D); run(300);
    evt_rand = 1'b0;
    // R6: clear selections
    sect = "R6";
    wr(3'd1, 8'h08); wr(3'd2, 8'h05); wr(3'd0, 8'h48); wr(3'd4, 8'h00); run(30);
    wr(3'd3, 8'h09); wr(3'd0, 8'h90); run(40);
    wr(3'd0, 8'hD8); run(300);
    wr(3'd2, 8'h00); wr(3'd0, 8'h48); run(10);
    // R7: overflow with and without enable, and clear at 0xFF
    sect = "R7";
    wr(3'd0, 8'h20); wr(3'd4, 8'hF0); run(40);
    wr(3'd0, 8'h00); wr(3'd4, 8'hF0); run(40);
    wr(3'd2, 8'hFF); wr(3'd0, 8'h68); wr(3'd4, 8'hF0); run(40);
    // R8: counter write restarts prescaler phase
    sect = "R8";
    wr(3'd0, 8'h00); wr(3'd1, 8'h0A); run(5);
    wr(3'd4, 8'h40); run(20);
    run(3); wr(3'd4, 8'h80); run(30);
    // R10: unused addresses change nothing
    sect = "R10";
    wr(3'd5, 8'hFF); wr(3'd6, 8'h00); wr(3'd7, 8'h1F); run(40);
    // R5: random mix
    sect = "R5";
    evt_rand = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      if ($urandom % 8 == 0) begin
        logic [2:0] a;
        logic [7:0] d;
        a = 3'($urandom % 8);
        d = 8'($urandom);
        if (a == 3'd1) d = {3'b000, 2'($urandom), 3'($urandom % 4)};
        cyc(1'b1, a, d, 1'($urandom % 2));
      end else begin
        cyc(1'b0, 3'd0, 8'h00, 1'($urandom % 2));
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired in section %s", sect);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule